// File: doc/BRIEF.md
# Slot-Table Time-Division Memory Arbiter

This block decides, once per clock, which of several clients may issue the next access to a single memory port. A table of 64 entries, loaded by software one entry at a time, names the owner of each time slot. A slot pointer walks the table in a circle. It moves on by one entry each time an access is granted. When the owner of the current slot is requesting, the owner wins. When the owner is idle, or the entry names no valid client, the slot goes to the lowest-numbered client that is requesting. A client with no reserved slots can therefore still reach memory, but only through this fallback.

Each client also has a programmable burst limit. The limit of the winning client is presented with the grant so that the memory controller can size the access. Both the slot table and the burst limits are written through one configuration port. A kind bit selects between the two targets. The default build serves 15 clients. A 9-client build only needs a different parameter value.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: During and straight after reset, `grant`, `grant_idx` and `grant_burst` are all zero. Slot s of the table holds client s mod NUM_CLIENTS, and every burst limit is 3.
- R2: The table entry at the slot pointer names a valid client that is requesting. The clock edge then grants that client.
- R3: The current slot's owner is not requesting but another client is. The grant goes to the lowest-index requesting client.
- R4: With no request bits set at a clock edge, all three outputs are zero after that edge and the slot pointer keeps its value.
- R5: Every edge that issues a grant advances the slot pointer by one, and slot 63 is followed by slot 0.
- R6: A table entry whose value is NUM_CLIENTS or above (15 in the default build) has no owner. Its slot is always resolved by the lowest-index rule of R3.
- R7: A slot write (`cfg_we`=1, `cfg_kind`=0, `cfg_addr`=slot, `cfg_data`=client) is captured at an edge. Evaluations at later edges see it, and the evaluation made at the same edge still uses the old entry.
- R8: A burst write (`cfg_we`=1, `cfg_kind`=1, `cfg_addr`=client, `cfg_data`=limit) changes the limit reported with later grants to that client. A grant decided at the same edge still carries the old limit.
- R9: `grant` has at most one bit set. That bit is the bit numbered `grant_idx`, and the client it names was requesting at the deciding edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_CLIENTS | Per-client request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 selects a slot entry, 1 selects a burst limit |
| cfg_addr | input | ADDR_W | Slot number or client number being written |
| cfg_data | input | DATA_W | Client index for a slot, or burst limit |
| grant | output | NUM_CLIENTS | One-hot grant, registered |
| grant_idx | output | IDX_W | Index of the granted client, zero when idle |
| grant_burst | output | BURST_W | Burst limit of the granted client, zero when idle |

## Verification
Suppose the slot pointer drifts by one, or it moves on a cycle with no grant. The sequence of owners granted under continuous all-client requests then shifts against the table contents. This shows on `grant_idx` at the first grant after the fault and on every grant after that, so the bench tracks the pointer in its own model and compares every cycle. A corrupted table entry or burst limit surfaces the next time the pointer reaches that slot, or the next time that client wins. The all-request sweeps, which cover the whole table twice, bound that delay to 64 grants.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

    typedef enum logic {
        CFG_SLOT  = 1'b0,
        CFG_BURST = 1'b1
    } cfg_kind_e;

    typedef enum logic [1:0] {
        PICK_NONE     = 2'd0,
        PICK_OWNER    = 2'd1,
        PICK_FALLBACK = 2'd2
    } pick_e;

    localparam int DEFAULT_BURST = 3;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 15,
    parameter int IDX_W       = 4,
    parameter int SLOT_W      = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [IDX_W-1:0]  wr_owner,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [IDX_W-1:0]  rd_owner,
    output logic              rd_valid
);
    logic [IDX_W-1:0] entry [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SLOTS; s++)
                entry[s] <= IDX_W'(s % NUM_CLIENTS);
        end else if (wr_en && ({1'b0, wr_slot} < (SLOT_W+1)'(NUM_SLOTS))) begin
            entry[wr_slot] <= wr_owner;
        end
    end

    always_comb begin
        rd_owner = entry[rd_slot];
        rd_valid = ({1'b0, rd_owner} < (IDX_W+1)'(NUM_CLIENTS));
    end
endmodule

// File: rtl/tdm_burst_regs.sv
module tdm_burst_regs import tdm_arb_pkg::*; #(
    parameter int NUM_CLIENTS = 15,
    parameter int IDX_W       = 4,
    parameter int BURST_W     = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_client,
    input  logic [BURST_W-1:0] wr_limit,
    input  logic [IDX_W-1:0]   rd_client,
    output logic [BURST_W-1:0] rd_limit
);
    logic [BURST_W-1:0] limit [NUM_CLIENTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CLIENTS; c++)
                limit[c] <= BURST_W'(DEFAULT_BURST);
        end else if (wr_en) begin
            for (int c = 0; c < NUM_CLIENTS; c++)
                if (wr_client == IDX_W'(c))
                    limit[c] <= wr_limit;
        end
    end

    always_comb begin
        rd_limit = '0;
        for (int c = 0; c < NUM_CLIENTS; c++)
            if (rd_client == IDX_W'(c))
                rd_limit = limit[c];
    end
endmodule

// File: rtl/tdm_pick.sv
module tdm_pick import tdm_arb_pkg::*; #(
    parameter int NUM_CLIENTS = 15,
    parameter int IDX_W       = 4
) (
    input  logic [NUM_CLIENTS-1:0] req,
    input  logic [IDX_W-1:0]       owner,
    input  logic                   owner_valid,
    output pick_e                  kind,
    output logic [IDX_W-1:0]       win_idx
);
    logic             owner_req;
    logic             any_req;
    logic [IDX_W-1:0] low_idx;

    always_comb begin
        owner_req = 1'b0;
        for (int c = 0; c < NUM_CLIENTS; c++)
            if (owner == IDX_W'(c))
                owner_req = req[c];
        owner_req = owner_req && owner_valid;
    end

    always_comb begin
        low_idx = '0;
        any_req = 1'b0;
        for (int c = NUM_CLIENTS - 1; c >= 0; c--) begin
            if (req[c]) begin
                low_idx = IDX_W'(c);
                any_req = 1'b1;
            end
        end
    end

    always_comb begin
        if (owner_req) begin
            kind    = PICK_OWNER;
            win_idx = owner;
        end else if (any_req) begin
            kind    = PICK_FALLBACK;
            win_idx = low_idx;
        end else begin
            kind    = PICK_NONE;
            win_idx = '0;
        end
    end
endmodule

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter import tdm_arb_pkg::*; #(
    parameter int NUM_CLIENTS = 15,
    parameter int NUM_SLOTS   = 64,
    parameter int BURST_W     = 4,
    parameter int IDX_W       = $clog2(NUM_CLIENTS),
    parameter int SLOT_W      = $clog2(NUM_SLOTS),
    parameter int ADDR_W      = max2(SLOT_W, IDX_W),
    parameter int DATA_W      = max2(IDX_W, BURST_W)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CLIENTS-1:0] req,
    input  logic                   cfg_we,
    input  logic                   cfg_kind,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]      cfg_data,
    output logic [NUM_CLIENTS-1:0] grant,
    output logic [IDX_W-1:0]       grant_idx,
    output logic [BURST_W-1:0]     grant_burst
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0]  slot_ptr;
    logic [IDX_W-1:0]   cur_owner;
    logic               cur_owner_valid;
    pick_e              pick_kind;
    logic [IDX_W-1:0]   win_idx;
    logic [BURST_W-1:0] win_burst;
    logic               slot_we;
    logic               burst_we;

    always_comb begin
        slot_we  = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_SLOT);
        burst_we = cfg_we && (cfg_kind_e'(cfg_kind) == CFG_BURST);
    end

    tdm_slot_table #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_CLIENTS(NUM_CLIENTS),
        .IDX_W(IDX_W), .SLOT_W(SLOT_W)
    ) table_i (
        .clk(clk), .rst(rst),
        .wr_en(slot_we), .wr_slot(cfg_addr[SLOT_W-1:0]), .wr_owner(cfg_data[IDX_W-1:0]),
        .rd_slot(slot_ptr), .rd_owner(cur_owner), .rd_valid(cur_owner_valid)
    );

    tdm_pick #(.NUM_CLIENTS(NUM_CLIENTS), .IDX_W(IDX_W)) pick_i (
        .req(req), .owner(cur_owner), .owner_valid(cur_owner_valid),
        .kind(pick_kind), .win_idx(win_idx)
    );

    tdm_burst_regs #(.NUM_CLIENTS(NUM_CLIENTS), .IDX_W(IDX_W), .BURST_W(BURST_W)) burst_i (
        .clk(clk), .rst(rst),
        .wr_en(burst_we), .wr_client(cfg_addr[IDX_W-1:0]), .wr_limit(cfg_data[BURST_W-1:0]),
        .rd_client(win_idx), .rd_limit(win_burst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_ptr    <= '0;
            grant       <= '0;
            grant_idx   <= '0;
            grant_burst <= '0;
        end else if (pick_kind != PICK_NONE) begin
            grant       <= NUM_CLIENTS'(1) << win_idx;
            grant_idx   <= win_idx;
            grant_burst <= win_burst;
            slot_ptr    <= (slot_ptr == LAST_SLOT) ? '0 : slot_ptr + 1'b1;
        end else begin
            grant       <= '0;
            grant_idx   <= '0;
            grant_burst <= '0;
        end
    end
endmodule

// File: rtl/tdm_slot_arbiter_chk.sv
module tdm_slot_arbiter_chk #(
    parameter int NUM_CLIENTS = 15,
    parameter int NUM_SLOTS   = 64,
    parameter int IDX_W       = 4,
    parameter int SLOT_W      = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_CLIENTS-1:0] req,
    input logic [NUM_CLIENTS-1:0] grant,
    input logic [IDX_W-1:0]       grant_idx,
    input logic [SLOT_W-1:0]      ptr,
    input logic [IDX_W-1:0]       owner,
    input logic                   owner_valid
);
    logic owner_req;
    logic [SLOT_W-1:0] ptr_next;

    always_comb begin
        owner_req = 1'b0;
        for (int c = 0; c < NUM_CLIENTS; c++)
            if (owner_valid && owner == IDX_W'(c))
                owner_req = req[c];
        ptr_next = (ptr == SLOT_W'(NUM_SLOTS - 1)) ? '0 : ptr + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (grant == '0 && grant_idx == '0));

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R9
    grant_was_req_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> ((grant & $past(req)) == grant && grant == (NUM_CLIENTS'(1) << grant_idx)));

    // R2
    owner_wins_chk: assert property (@(posedge clk) disable iff (rst)
        owner_req |=> (grant_idx == $past(owner) && |grant));

    // R3
    fallback_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (|req && !owner_req) |=> (|grant && (($past(req) & (grant - 1'b1)) == '0)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(|req) |=> (grant == '0 && ptr == $past(ptr)));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |=> (ptr == $past(ptr_next)));
endmodule

bind tdm_slot_arbiter tdm_slot_arbiter_chk #(
    .NUM_CLIENTS(NUM_CLIENTS), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
) chk_i (
    .clk(clk), .rst(rst), .req(req), .grant(grant), .grant_idx(grant_idx),
    .ptr(slot_ptr), .owner(cur_owner), .owner_valid(cur_owner_valid)
);

// File: tb/tdm_slot_arbiter_test.sv
module tdm_slot_arbiter_test;
    localparam int CLK_P = 10;
    localparam int NC    = 15;
    localparam int NS    = 64;
    localparam int IW    = 4;
    localparam int BW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] req = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_kind = 1'b0;
    logic [5:0]    cfg_addr = '0;
    logic [3:0]    cfg_data = '0;
    logic [NC-1:0] grant;
    logic [IW-1:0] grant_idx;
    logic [BW-1:0] grant_burst;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int mtbl   [NS];
    int mburst [NC];
    int mptr;

    always #(CLK_P/2) clk = ~clk;

    tdm_slot_arbiter uut (
        .clk(clk), .rst(rst), .req(req), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .grant(grant), .grant_idx(grant_idx), .grant_burst(grant_burst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, model the edge, check at next negedge
    task automatic tick(input logic [NC-1:0] r, input bit we, input bit kind,
                        input int addr, input int data, input string force_tag);
        int own, win, eb;
        string tag;
        logic [NC-1:0] eg;
        req = r; cfg_we = we; cfg_kind = kind;
        cfg_addr = 6'(addr); cfg_data = 4'(data);
        @(posedge clk);
        own = mtbl[mptr];
        win = -1;
        if (r != 0) begin
            if (own < NC && r[own]) win = own;
            else begin
                for (int c = NC - 1; c >= 0; c--) if (r[c]) win = c;
            end
        end
        if (r == 0) tag = "R4";
        else if (mptr == NS - 1) tag = "R5";
        else if (own >= NC) tag = "R6";
        else if (r[own]) tag = "R2";
        else tag = "R3";
        if (force_tag != "") tag = force_tag;
        eg = (win >= 0) ? (NC'(1) << win) : '0;
        eb = (win >= 0) ? mburst[win] : 0;
        if (win >= 0) mptr = (mptr + 1) % NS;
        if (we && !kind) mtbl[addr] = data;
        if (we && kind && addr < NC) mburst[addr] = data;
        @(negedge clk);
        cfg_we = 1'b0;
        check(grant == eg, tag, int'(grant), int'(eg));
        check(int'(grant_idx) == ((win >= 0) ? win : 0), tag, int'(grant_idx), (win >= 0) ? win : 0);
        check(int'(grant_burst) == eb, "R8", int'(grant_burst), eb);
        check($countones(grant) <= 1, "R9", $countones(grant), 1);
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lf;
        logic [NC-1:0] r;
        for (int s = 0; s < NS; s++) mtbl[s] = s % NC;
        for (int c = 0; c < NC; c++) mburst[c] = 3;
        mptr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(grant == '0, "R1", int'(grant), 0);
        check(grant_idx == '0, "R1", int'(grant_idx), 0);
        check(grant_burst == '0, "R1", int'(grant_burst), 0);

        // R1 R2 R5: all clients requesting, default table, two laps
        for (int k = 0; k < 2 * NS + 3; k++) tick('1, 0, 0, 0, 0, "");

        // R2 R3: each single client alone for several slots
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < 9; k++) tick(NC'(1) << c, 0, 0, 0, 0, "");

        // R4: idle cycles keep the pointer
        for (int k = 0; k < 5; k++) tick('0, 0, 0, 0, 0, "R4");
        tick('1, 0, 0, 0, 0, "R4");

        // mixed patterns with idle gaps
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            r = (lf[15:13] == 3'b000) ? '0 : lf[14:0] & {lf[3:0], lf[15:5]};
            tick(r, 0, 0, 0, 0, "");
        end

        // R7: write next slot and current slot in the same cycle as an evaluation
        tick('1, 1, 0, (mptr + 1) % NS, 5, "R7");
        tick('1, 1, 0, mptr, 9, "R7");
        tick('1, 0, 0, 0, 0, "R7");

        // R6: mark slots invalid (value 15), then run patterns over them
        for (int s = 0; s < NS; s += 2) tick('0, 1, 0, s, 15, "R4");
        for (int k = 0; k < 2 * NS; k++) tick(NC'(16'h6A50 >> (k % 5)), 0, 0, 0, 0, "");
        for (int k = 0; k < NS; k++) tick('1, 0, 0, 0, 0, "");

        // R8: new burst limits, and a write racing a grant to the same client
        for (int c = 0; c < NC; c++) tick('0, 1, 1, c, 14 - c, "R4");
        for (int k = 0; k < NS; k++) tick('1, 0, 0, 0, 0, "");
        tick(NC'(1), 1, 1, 0, 7, "R8");
        tick(NC'(1), 0, 0, 0, 0, "R8");
        for (int c = 0; c < NC; c++) tick(NC'(1) << c, 0, 0, 0, 0, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule